// File: doc/BRIEF.md
# Converted-Sample Output Queue

This block sits between a sample-rate conversion engine and the register read port of an audio subsystem. The engine pushes each finished 32-bit stereo word (two 16-bit channels) into a 16-deep first-in first-out store. Software pulls words out through a single read strobe and a registered read-data port. Before a word is captured, the port can exchange its two channels and reverse the byte order inside each channel.

Three sticky flags report events. The fill flag fires when the stored count reaches a selectable level. The empty-read flag records a read of an empty store. The lost-slot flag records a push that arrived while the store was full. Each flag has its own enable onto one interrupt line. A clear command empties the store at once. Each flag has its own strobe that models software writing zero to it.

Top module: `conv_out_fifo`

## Requirements
- R1: After reset, fill_count is 0, all three flags are 0, irq is 0 and rd_data is 0.
- R2: Words leave in the order they were pushed. rd_data shows the word taken by a read strobe from the clock edge that samples that strobe. fill_count rises by one per push and falls by one per read.
- R3: The store holds 16 words, and fill_count (5 bits) covers 0 to 16.
- R4: A read strobe while the store is empty leaves rd_data at the value of the previous read, and fill_count stays 0.
- R5: A read strobe while the store is empty sets undr_flag at the same clock edge.
- R6: A push while the store holds 16 words and no read is taken replaces the most recently written word. fill_count stays 16 and ovwr_flag sets.
- R7: trig_sel picks the fill level: code 0 means 1 word, code 1 means 4, code 2 means 8, code 3 means 12. full_flag sets at the edge where fill_count goes from below the level to at or above it.
- R8: A clear strobe (full_flag_clr, undr_flag_clr, ovwr_flag_clr) drops its flag at the next edge. If that flag's set event happens in the same cycle, the set wins.
- R9: irq is the OR of each flag ANDed with its own enable (full_irq_en, undr_irq_en, ovwr_irq_en). A set flag whose enable is 0 does not raise irq.
- R10: With chan_swap = 1, the upper and lower 16-bit halves of the stored word are exchanged before the word reaches rd_data.
- R11: With byte_swap = 1, the two bytes inside each 16-bit half are exchanged. This is applied after any channel swap: 32'h11223344 reads as 32'h22114433 with byte_swap alone and as 32'h44332211 with both swaps.
- R12: clr sets fill_count to 0 at the next edge. A push or read in the clr cycle is ignored, rd_data keeps its value, and the flags are not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Conversion engine delivers a word this cycle |
| push_data | input | 32 | Converted stereo word, left channel in the upper half |
| rd_en | input | 1 | Read strobe from the register port |
| rd_data | output | 32 | Last word read, after formatting |
| clr | input | 1 | Empty the store |
| trig_sel | input | 2 | Fill-level code |
| chan_swap | input | 1 | Exchange the 16-bit halves on read |
| byte_swap | input | 1 | Reverse the bytes inside each half on read |
| full_irq_en | input | 1 | Enable full_flag onto irq |
| undr_irq_en | input | 1 | Enable undr_flag onto irq |
| ovwr_irq_en | input | 1 | Enable ovwr_flag onto irq |
| full_flag_clr | input | 1 | Clear strobe for full_flag |
| undr_flag_clr | input | 1 | Clear strobe for undr_flag |
| ovwr_flag_clr | input | 1 | Clear strobe for ovwr_flag |
| fill_count | output | 5 | Number of stored words |
| full_flag | output | 1 | Fill level reached |
| undr_flag | output | 1 | Read taken while empty |
| ovwr_flag | output | 1 | Push arrived while full |
| irq | output | 1 | Combined enabled flags |

## Verification
A read or write pointer that goes out of step with the count shows up as a wrong word on rd_data at the very next read. That is a word out of order, or a repeat of one that was already read. A count error moves full_flag to the wrong edge. It also makes an empty read return fresh data rather than the held word, or lets an overwrite land in the wrong slot, and a full drain of 16 reads exposes that word. A formatting fault changes rd_data on the first read taken with the affected swap selected.

// File: rtl/cfo_pkg.sv
package cfo_pkg;

  // Fill level picked by the 2-bit code: 0 -> 1, otherwise code * depth/4.
  function automatic int unsigned trig_level(input logic [1:0] code,
                                             input int unsigned depth);
    if (code == 2'd0) return 1;
    return int'(code) * (depth / 4);
  endfunction

  // Count after one cycle of push/pop decisions.
  function automatic int unsigned next_count(input int unsigned cnt,
                                             input logic grow,
                                             input logic shrink,
                                             input logic wipe);
    if (wipe) return 0;
    if (grow && !shrink) return cnt + 1;
    if (shrink && !grow) return cnt - 1;
    return cnt;
  endfunction

endpackage

// File: rtl/cfo_store.sv
module cfo_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push_valid,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_word,
  output logic [$clog2(DEPTH+1)-1:0] cnt_q,
  output logic [$clog2(DEPTH+1)-1:0] cnt_nxt,
  output logic                       rd_ok,
  output logic                       undr_ev,
  output logic                       ovwr_ev
);
  import cfo_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic              empty, full, wr_new;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign rd_ok   = rd_en && !empty && !clr;
  assign undr_ev = rd_en && empty && !clr;
  assign wr_new  = push_valid && !clr && (!full || rd_ok);
  assign ovwr_ev = push_valid && !clr && full && !rd_ok;
  assign rd_word = mem[rptr_q];
  assign cnt_nxt = CNT_W'(next_count(int'(cnt_q), wr_new, rd_ok, clr));

  always_ff @(posedge clk) begin
    if (wr_new)
      mem[wptr_q] <= push_data;
    else if (ovwr_ev)
      mem[PTR_W'(wptr_q - 1'b1)] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (clr) begin
        wptr_q <= '0;
        rptr_q <= '0;
      end else begin
        if (wr_new) wptr_q <= PTR_W'(wptr_q + 1'b1);
        if (rd_ok)  rptr_q <= PTR_W'(rptr_q + 1'b1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R3
  AST_OVWR_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovwr_ev |=> (cnt_q == FULL_CNT)); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R12
  AST_EMPTY_READ_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (undr_ev && !push_valid) |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/cfo_rdport.sv
module cfo_rdport #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ok,
  input  logic              undr_ev,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              chan_swap,
  input  logic              byte_swap,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NB_H   = HALF_W / 8;

  logic [DATA_W-1:0] halves_x, bytes_x, fmt_word, hold_q;

  assign halves_x = {rd_word[HALF_W-1:0], rd_word[DATA_W-1:HALF_W]};
  wire [DATA_W-1:0] stage1 = chan_swap ? halves_x : rd_word;

  for (genvar h = 0; h < 2; h++) begin : g_half
    for (genvar b = 0; b < NB_H; b++) begin : g_byte
      assign bytes_x[h*HALF_W + b*8 +: 8] = stage1[h*HALF_W + (NB_H-1-b)*8 +: 8];
    end
  end

  assign fmt_word = byte_swap ? bytes_x : stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= '0;
    else if (rd_ok) hold_q <= fmt_word;
  end

  assign rd_data = hold_q;

  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    undr_ev |=> $stable(rd_data)); // R4
  AST_NO_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(rd_data)); // R12

endmodule

// File: rtl/cfo_flags.sv
module cfo_flags #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(DEPTH+1)-1:0] cnt_q,
  input  logic [$clog2(DEPTH+1)-1:0] cnt_nxt,
  input  logic [1:0]                 trig_sel,
  input  logic                       undr_ev,
  input  logic                       ovwr_ev,
  input  logic                       full_flag_clr,
  input  logic                       undr_flag_clr,
  input  logic                       ovwr_flag_clr,
  input  logic                       full_irq_en,
  input  logic                       undr_irq_en,
  input  logic                       ovwr_irq_en,
  output logic                       full_flag,
  output logic                       undr_flag,
  output logic                       ovwr_flag,
  output logic                       irq
);
  import cfo_pkg::*;

  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] level;
  logic             full_hit;
  logic             full_q, undr_q, ovwr_q;

  assign level    = CNT_W'(trig_level(trig_sel, DEPTH));
  assign full_hit = (cnt_nxt >= level) && (cnt_q < level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      undr_q <= 1'b0;
      ovwr_q <= 1'b0;
    end else begin
      full_q <= (full_q && !full_flag_clr) || full_hit;
      undr_q <= (undr_q && !undr_flag_clr) || undr_ev;
      ovwr_q <= (ovwr_q && !ovwr_flag_clr) || ovwr_ev;
    end
  end

  assign full_flag = full_q;
  assign undr_flag = undr_q;
  assign ovwr_flag = ovwr_q;
  assign irq = (full_q && full_irq_en) || (undr_q && undr_irq_en) ||
               (ovwr_q && ovwr_irq_en);

  AST_UNDR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    undr_ev |=> undr_flag); // R5
  AST_OVWR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovwr_ev |=> ovwr_flag); // R6
  AST_FULL_RISE_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_flag) |-> (cnt_q >= level || $past(trig_sel) != trig_sel)); // R7
  AST_FLAG_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (undr_flag_clr && !undr_ev) |=> !undr_flag); // R8

endmodule

// File: rtl/conv_out_fifo.sv
module conv_out_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_valid,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       rd_en,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       clr,
  input  logic [1:0]                 trig_sel,
  input  logic                       chan_swap,
  input  logic                       byte_swap,
  input  logic                       full_irq_en,
  input  logic                       undr_irq_en,
  input  logic                       ovwr_irq_en,
  input  logic                       full_flag_clr,
  input  logic                       undr_flag_clr,
  input  logic                       ovwr_flag_clr,
  output logic [$clog2(DEPTH+1)-1:0] fill_count,
  output logic                       full_flag,
  output logic                       undr_flag,
  output logic                       ovwr_flag,
  output logic                       irq
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] rd_word;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              rd_ok, undr_ev, ovwr_ev;

  cfo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push_valid(push_valid),
    .push_data(push_data), .rd_en(rd_en), .rd_word(rd_word),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .rd_ok(rd_ok),
    .undr_ev(undr_ev), .ovwr_ev(ovwr_ev)
  );

  cfo_rdport #(.DATA_W(DATA_W)) u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_ok(rd_ok), .undr_ev(undr_ev),
    .rd_word(rd_word), .chan_swap(chan_swap), .byte_swap(byte_swap),
    .rd_data(rd_data)
  );

  cfo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .trig_sel(trig_sel), .undr_ev(undr_ev), .ovwr_ev(ovwr_ev),
    .full_flag_clr(full_flag_clr), .undr_flag_clr(undr_flag_clr),
    .ovwr_flag_clr(ovwr_flag_clr), .full_irq_en(full_irq_en),
    .undr_irq_en(undr_irq_en), .ovwr_irq_en(ovwr_irq_en),
    .full_flag(full_flag), .undr_flag(undr_flag), .ovwr_flag(ovwr_flag),
    .irq(irq)
  );

  assign fill_count = cnt_q;

  AST_READ_TAKES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !push_valid) |=> (fill_count == $past(fill_count) - 1'b1)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (full_flag || undr_flag || ovwr_flag)); // R9

endmodule

// File: tb/conv_out_fifo_bench.sv
module conv_out_fifo_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 0, rd_en = 0, clr = 0;
  logic [31:0] push_data = '0;
  logic [1:0]  trig_sel = 0;
  logic        chan_swap = 0, byte_swap = 0;
  logic        full_irq_en = 0, undr_irq_en = 0, ovwr_irq_en = 0;
  logic        full_flag_clr = 0, undr_flag_clr = 0, ovwr_flag_clr = 0;
  logic [31:0] rd_data;
  logic [4:0]  fill_count;
  logic        full_flag, undr_flag, ovwr_flag, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] sb[$];
  logic [31:0] last_exp = '0;
  string cur_tag = "R2";

  always #(CLK_P/2) clk = ~clk;

  conv_out_fifo u_conv_out_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .rd_en(rd_en), .rd_data(rd_data), .clr(clr), .trig_sel(trig_sel),
    .chan_swap(chan_swap), .byte_swap(byte_swap), .full_irq_en(full_irq_en),
    .undr_irq_en(undr_irq_en), .ovwr_irq_en(ovwr_irq_en),
    .full_flag_clr(full_flag_clr), .undr_flag_clr(undr_flag_clr),
    .ovwr_flag_clr(ovwr_flag_clr), .fill_count(fill_count),
    .full_flag(full_flag), .undr_flag(undr_flag), .ovwr_flag(ovwr_flag),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected formatting, byte by byte from the most significant end.
  function automatic logic [31:0] exp_fmt(input logic [31:0] w, input bit cs, input bit bs);
    logic [7:0] b [4];
    logic [7:0] t;
    for (int i = 0; i < 4; i++) b[i] = w[31-8*i -: 8];
    if (cs) begin
      t = b[0]; b[0] = b[2]; b[2] = t;
      t = b[1]; b[1] = b[3]; b[3] = t;
    end
    if (bs) begin
      t = b[0]; b[0] = b[1]; b[1] = t;
      t = b[2]; b[2] = b[3]; b[3] = t;
    end
    return {b[0], b[1], b[2], b[3]};
  endfunction

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    push_valid = 1; push_data = d;
    if (sb.size() == 16) sb[$] = d; else sb.push_back(d);
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic pop();
    @(negedge clk);
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic strobe_clr_flags();
    @(negedge clk);
    full_flag_clr = 1; undr_flag_clr = 1; ovwr_flag_clr = 1;
    @(negedge clk);
    full_flag_clr = 0; undr_flag_clr = 0; ovwr_flag_clr = 0;
  endtask

  // Monitor: compares every read against the scoreboard queue.
  logic        mon_rd;
  logic [31:0] mon_exp;
  string       mon_tag;
  always @(posedge clk) begin
    mon_rd = rd_en && rst_n && !clr;
    if (mon_rd) begin
      if (sb.size() > 0) begin
        mon_exp = exp_fmt(sb.pop_front(), chan_swap, byte_swap);
        mon_tag = cur_tag;
      end else begin
        mon_exp = last_exp;
        mon_tag = "R4";
      end
      #(CLK_P/4);
      check(mon_tag, rd_data, mon_exp);
      last_exp = mon_exp;
    end
  end

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {27'd0, fill_count}, 32'd0);
    check("R1", {29'd0, full_flag, undr_flag, ovwr_flag}, 32'd0);
    check("R1", {31'd0, irq}, 32'd0);
    check("R1", rd_data, 32'd0);
    rst_n = 1;

    // R7 level 1, R9 enabled full flag onto irq
    full_irq_en = 1;
    push(32'hA0A0_0001);
    check("R7", {31'd0, full_flag}, 32'd1);
    check("R9", {31'd0, irq}, 32'd1);
    check("R2", {27'd0, fill_count}, 32'd1);
    pop();
    check("R2", {27'd0, fill_count}, 32'd0);
    strobe_clr_flags();
    check("R8", {31'd0, full_flag}, 32'd0);

    // R4/R5/R9 empty read
    pop();
    check("R4", {27'd0, fill_count}, 32'd0);
    check("R5", {31'd0, undr_flag}, 32'd1);
    check("R9", {31'd0, irq}, 32'd0);
    undr_irq_en = 1;
    @(negedge clk);
    check("R9", {31'd0, irq}, 32'd1);
    strobe_clr_flags();
    check("R8", {31'd0, undr_flag}, 32'd0);

    // R7 level 8, R3 capacity, R6 overwrite
    trig_sel = 2'd2;
    for (int i = 0; i < 7; i++) push(32'h1000_0000 + i);
    check("R7", {31'd0, full_flag}, 32'd0);
    push(32'h1000_0007);
    check("R7", {31'd0, full_flag}, 32'd1);
    for (int i = 8; i < 16; i++) push(32'h1000_0000 + i);
    check("R3", {27'd0, fill_count}, 32'd16);
    check("R6", {31'd0, ovwr_flag}, 32'd0);
    push(32'hDEAD_BEEF);
    check("R6", {27'd0, fill_count}, 32'd16);
    check("R6", {31'd0, ovwr_flag}, 32'd1);
    ovwr_irq_en = 1; full_irq_en = 0; undr_irq_en = 0;
    strobe_clr_flags();
    check("R8", {29'd0, full_flag, undr_flag, ovwr_flag}, 32'd0);
    cur_tag = "R6";
    for (int i = 0; i < 16; i++) pop();
    check("R3", {27'd0, fill_count}, 32'd0);
    cur_tag = "R2";

    // R7 level 4 and level 12
    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) push(32'h2000_0000 + i);
    check("R7", {31'd0, full_flag}, 32'd0);
    push(32'h2000_0003);
    check("R7", {31'd0, full_flag}, 32'd1);
    strobe_clr_flags();
    trig_sel = 2'd3;
    for (int i = 4; i < 11; i++) push(32'h2000_0000 + i);
    check("R7", {31'd0, full_flag}, 32'd0);
    push(32'h2000_000B);
    check("R7", {31'd0, full_flag}, 32'd1);

    // R12 clear with a push in the same cycle
    @(negedge clk);
    clr = 1; push_valid = 1; push_data = 32'h5555_5555; sb.delete();
    @(negedge clk);
    clr = 0; push_valid = 0;
    check("R12", {27'd0, fill_count}, 32'd0);
    check("R12", {31'd0, full_flag}, 32'd1);
    pop();
    check("R12", rd_data, last_exp);
    strobe_clr_flags();

    // R10/R11 formatting
    cur_tag = "R10";
    chan_swap = 1;
    push(32'h1122_3344); pop();
    check("R10", rd_data, 32'h3344_1122);
    cur_tag = "R11";
    chan_swap = 0; byte_swap = 1;
    push(32'h1122_3344); pop();
    check("R11", rd_data, 32'h2211_4433);
    chan_swap = 1;
    push(32'h1122_3344); pop();
    check("R11", rd_data, 32'h4433_2211);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule